// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block is a small translation cache that sits between a processor's address generation and its memory system. It holds recently used page mappings. Each mapping is tagged with a virtual page number and an address-space identifier, and it carries a physical frame number and two permission bits. Pages are 4 KB, so the low 12 bits of the address pass straight through and only the page number is translated.

Every lookup compares the request against all entries at once. One cycle later the block reports one of three outcomes: a translated physical address, a miss, or a protection fault. On a miss, software or an external page walker writes the missing mapping through the fill port. The block chooses the slot itself. A slot that already holds the same tag is reused first. Failing that, the lowest-numbered empty slot is used. When the table is full, a free-running pseudo-random generator picks the slot to replace. A flush input invalidates every entry in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset, every entry is invalid, every result output is low, and any lookup reports a miss.
- R2: A result appears exactly one cycle after the cycle in which `lk_valid` is high. `res_valid` pulses for that one cycle. With `res_valid` high, exactly one of `res_miss`, `res_fault` and `res_pa_valid` is high. With `res_valid` low, all three are low.
- R3: When a lookup hits with permission, `res_paddr` is the entry's frame number in bits [31:12] and the request's `lk_vaddr[11:0]` in bits [11:0].
- R4: A lookup matches an entry only if both the page number `lk_vaddr[31:12]` and `lk_asid` equal the stored tag. The same page under another identifier misses.
- R5: Permission bit 0 allows loads (`lk_store`=0) and bit 1 allows stores (`lk_store`=1). A hit without the needed bit raises `res_fault` with `res_pa_valid` low and `res_paddr` zero.
- R6: A miss raises `res_miss` and drives `res_paddr` to zero.
- R7: While any entry is invalid, a fill of a new tag takes an invalid slot and evicts no valid mapping, so sixteen distinct fills after reset all remain resident.
- R8: A fill whose tag is already present rewrites that same entry in place. Later lookups see the new frame and permissions, and no other mapping is lost.
- R9: When all entries are valid, a fill of a new tag replaces exactly one pseudo-randomly chosen entry. The new mapping hits, and all but one of the old mappings still hit.
- R10: A flush invalidates all entries in one cycle. A fill in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as a fill or flush sees the table contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the request |
| lk_store | input | 1 | 1 = store access, 0 = load access |
| fill_en | input | 1 | Write a mapping |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_asid | input | 8 | Address-space identifier of the mapping |
| fill_pfn | input | 20 | Physical frame number |
| fill_perm | input | 2 | Bit 0 load allowed, bit 1 store allowed |
| flush | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Result strobe |
| res_miss | output | 1 | No matching entry |
| res_fault | output | 1 | Entry found but access not permitted |
| res_pa_valid | output | 1 | Translation succeeded |
| res_paddr | output | 32 | Physical address, zero unless `res_pa_valid` |

## Verification
The embedded properties check, on every cycle, the one-cycle result timing, that the three outcomes are mutually exclusive, that the page offset passes through on success, that no two valid entries share a tag, that a flush leaves nothing valid, that the random generator never locks at zero, and that a fill never picks an occupied slot while a free one exists. The directed scenarios are the only evidence for the translation values themselves, the identifier and permission decisions, in-place rewriting, and the count of mappings that survive a replacement in a full table. They also cover the ordering when a lookup coincides with a fill or flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PG_OFS_W  = 12;
  localparam int PERM_W    = 2;
  localparam int PERM_LOAD = 0;
  localparam int PERM_STOR = 1;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_MISS  = 2'd1,
    OUT_FAULT = 2'd2,
    OUT_XLATE = 2'd3
  } lookup_kind_e;

  function automatic logic access_ok(input logic [PERM_W-1:0] perm,
                                     input logic is_store);
    return is_store ? perm[PERM_STOR] : perm[PERM_LOAD];
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W     = 8,
  parameter int OUT_W = 4,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end

  assign rnd = state_q[OUT_W-1:0];

  // R9: the replacement source must never lock up at the all-zero state
  a_r9_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
  input  logic [N-1:0][ASID_W-1:0] tag_asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tag_vpn[g] == key_vpn)
                        && (tag_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     same_tag,
  input  logic [IDX_W-1:0] rnd,
  output logic [IDX_W-1:0] slot
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] same_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    same_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (same_tag[i]) same_idx = IDX_W'(i);
    end
    if (|same_tag)       slot = same_idx;
    else if (free_found) slot = free_idx;
    else                 slot = rnd;
  end

  // R7: while room remains, a new tag never lands on a live entry
  a_r7_free_first: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(|same_tag) && !(&valid)) |-> !valid[slot]);
  // R8: a repeated tag is written back onto its own entry
  a_r8_reuse_slot: assert property (@(posedge clk) disable iff (rst)
    (fill_en && (|same_tag)) |-> same_tag[slot]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int LFSR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lk_valid,
  input  logic [VPN_W+PG_OFS_W-1:0]  lk_vaddr,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic                       lk_store,
  input  logic                       fill_en,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [ASID_W-1:0]          fill_asid,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic [PERM_W-1:0]          fill_perm,
  input  logic                       flush,
  output logic                       res_valid,
  output logic                       res_miss,
  output logic                       res_fault,
  output logic                       res_pa_valid,
  output logic [PFN_W+PG_OFS_W-1:0]  res_paddr
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int PA_W  = PFN_W + PG_OFS_W;

  logic [N-1:0]             valid_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;

  logic [N-1:0]     lk_hit;
  logic [N-1:0]     fill_hit;
  logic [IDX_W-1:0] rnd_idx;
  logic [IDX_W-1:0] wr_slot;

  logic [VPN_W-1:0]  lk_vpn;
  logic [PFN_W-1:0]  sel_pfn;
  logic [PERM_W-1:0] sel_perm;
  lookup_kind_e      kind;

  assign lk_vpn = lk_vaddr[VPN_W+PG_OFS_W-1:PG_OFS_W];

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .hit_vec(lk_hit)
  );

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .hit_vec(fill_hit)
  );

  tlb_lfsr #(.W(LFSR_W), .OUT_W(IDX_W)) u_rnd (
    .clk(clk), .rst(rst), .rnd(rnd_idx)
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .fill_en(fill_en && !flush),
    .valid(valid_q), .same_tag(fill_hit), .rnd(rnd_idx), .slot(wr_slot)
  );

  // one-hot read of the matching entry
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_hit[i]) begin
        sel_pfn  = sel_pfn  | pfn_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
    end
    if (!lk_valid)                        kind = OUT_NONE;
    else if (!(|lk_hit))                  kind = OUT_MISS;
    else if (!access_ok(sel_perm, lk_store)) kind = OUT_FAULT;
    else                                  kind = OUT_XLATE;
  end

  // valid bits: reset and flush clear every entry at once
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (fill_en) valid_q[wr_slot] <= 1'b1;
  end

  // entry payload without reset, written one slot per cycle
  always_ff @(posedge clk) begin
    if (fill_en && !flush && !rst) begin
      vpn_q[wr_slot]  <= fill_vpn;
      asid_q[wr_slot] <= fill_asid;
      pfn_q[wr_slot]  <= fill_pfn;
      perm_q[wr_slot] <= fill_perm;
    end
  end

  // registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_miss     <= 1'b0;
      res_fault    <= 1'b0;
      res_pa_valid <= 1'b0;
      res_paddr    <= '0;
    end else begin
      res_valid    <= lk_valid;
      res_miss     <= (kind == OUT_MISS);
      res_fault    <= (kind == OUT_FAULT);
      res_pa_valid <= (kind == OUT_XLATE);
      res_paddr    <= (kind == OUT_XLATE)
                      ? {sel_pfn, lk_vaddr[PG_OFS_W-1:0]} : PA_W'(0);
    end
  end

  // R2: result strobe follows the request by exactly one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(lk_valid)));
  // R2: with a strobe, exactly one outcome flag
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_miss, res_fault, res_pa_valid}) == 1));
  // R2: no outcome flags without a strobe
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_miss || res_fault || res_pa_valid));
  // R3: the page offset passes through untouched
  a_r3_offset_pass: assert property (@(posedge clk) disable iff (rst)
    res_pa_valid |-> (res_paddr[PG_OFS_W-1:0] == $past(lk_vaddr[PG_OFS_W-1:0])));
  // R5 and R6: no address is returned on a miss or a fault
  a_r5_no_addr_bad: assert property (@(posedge clk) disable iff (rst)
    (res_miss || res_fault) |-> (res_paddr == '0));
  // R8: a tag never lives in two entries
  a_r8_no_dup_tag: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit));
  // R10: a flush leaves no valid entry behind
  a_r10_flush_all: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush)) |-> (valid_q == '0));
endmodule

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [1:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        res_valid, res_miss, res_fault, res_pa_valid;
  logic [31:0] res_paddr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  tlb_fa uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_store(lk_store), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush(flush), .res_valid(res_valid),
    .res_miss(res_miss), .res_fault(res_fault), .res_pa_valid(res_pa_valid),
    .res_paddr(res_paddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [7:0] asid,
                         input logic [19:0] pfn, input logic [1:0] perm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid;
    fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // kind: 0 miss, 1 fault, 2 translated
  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input bit st, input int kind, input logic [31:0] pa,
                      input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
    check(res_valid, req, "res_valid", 32'(res_valid), 1);
    check(res_miss == (kind == 0), req, "res_miss", 32'(res_miss), 32'(kind == 0));
    check(res_fault == (kind == 1), req, "res_fault", 32'(res_fault), 32'(kind == 1));
    check(res_pa_valid == (kind == 2), req, "res_pa_valid", 32'(res_pa_valid), 32'(kind == 2));
    check(res_paddr == pa, req, "res_paddr", res_paddr, pa);
  endtask

  // returns 1 if the lookup translated
  task automatic probe(input logic [31:0] va, input logic [7:0] asid, output bit hit);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0;
    hit = res_pa_valid;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(!res_valid && !res_miss && !res_fault && !res_pa_valid && res_paddr == 0,
          "R1", "outputs after reset", {res_valid, res_miss, res_fault, res_pa_valid}, 0);
    look(32'h0000_0abc, 8'd0, 1'b0, 0, 32'h0, "R1");
    look(32'hffff_f000, 8'hff, 1'b1, 0, 32'h0, "R6");
    @(negedge clk);
    check(!res_valid && !res_miss, "R2", "strobe drops", 32'(res_valid), 0);
  endtask

  task automatic t_fill_hit();
    do_reset();
    for (int i = 0; i < 16; i++)
      do_fill(20'h10 + 20'(i), 8'd1, 20'h80000 + 20'(i * 3), 2'b11);
    for (int i = 0; i < 16; i++)
      look({20'h10 + 20'(i), 12'h5a5}, 8'd1, 1'(i % 2), 2,
           {20'h80000 + 20'(i * 3), 12'h5a5}, i == 0 ? "R3" : "R7");
  endtask

  task automatic t_asid();
    do_reset();
    do_fill(20'h12345, 8'd7, 20'h00abc, 2'b11);
    look(32'h1234_5010, 8'd7, 1'b0, 2, 32'h00ab_c010, "R4");
    look(32'h1234_5010, 8'd8, 1'b0, 0, 32'h0, "R4");
    look(32'h1234_6010, 8'd7, 1'b0, 0, 32'h0, "R4");
  endtask

  task automatic t_perm();
    do_reset();
    do_fill(20'h00005, 8'd2, 20'h00100, 2'b01);
    do_fill(20'h00006, 8'd2, 20'h00200, 2'b10);
    do_fill(20'h00007, 8'd2, 20'h00300, 2'b00);
    look(32'h0000_5fff, 8'd2, 1'b0, 2, 32'h0010_0fff, "R5");
    look(32'h0000_5fff, 8'd2, 1'b1, 1, 32'h0, "R5");
    look(32'h0000_6004, 8'd2, 1'b0, 1, 32'h0, "R5");
    look(32'h0000_6004, 8'd2, 1'b1, 2, 32'h0020_0004, "R5");
    look(32'h0000_7000, 8'd2, 1'b0, 1, 32'h0, "R5");
    look(32'h0000_7000, 8'd2, 1'b1, 1, 32'h0, "R5");
  endtask

  task automatic t_overwrite();
    bit hit;
    int alive;
    do_reset();
    for (int i = 0; i < 16; i++)
      do_fill(20'h200 + 20'(i), 8'd3, 20'h300 + 20'(i), 2'b11);
    do_fill(20'h205, 8'd3, 20'hbeef0, 2'b01);
    look(32'h0020_5123, 8'd3, 1'b0, 2, 32'hbeef_0123, "R8");
    look(32'h0020_5123, 8'd3, 1'b1, 1, 32'h0, "R8");
    alive = 0;
    for (int i = 0; i < 16; i++) begin
      probe({20'h200 + 20'(i), 12'h0}, 8'd3, hit);
      alive += int'(hit);
    end
    check(alive == 16, "R8", "resident mappings", 32'(alive), 16);
  endtask

  task automatic t_replace();
    bit hit;
    int alive;
    do_reset();
    for (int i = 0; i < 16; i++)
      do_fill(20'h400 + 20'(i), 8'd4, 20'h500 + 20'(i), 2'b11);
    do_fill(20'h9999, 8'd4, 20'h77777, 2'b11);
    look(32'h0999_9042, 8'd4, 1'b0, 2, 32'h7777_7042, "R9");
    alive = 0;
    for (int i = 0; i < 16; i++) begin
      probe({20'h400 + 20'(i), 12'h0}, 8'd4, hit);
      alive += int'(hit);
    end
    check(alive == 15, "R9", "old mappings surviving", 32'(alive), 15);
  endtask

  task automatic t_flush();
    do_reset();
    do_fill(20'h00aa, 8'd5, 20'h00bb, 2'b11);
    do_fill(20'h00ab, 8'd5, 20'h00bc, 2'b11);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    look(32'h000a_a000, 8'd5, 1'b0, 0, 32'h0, "R10");
    look(32'h000a_b000, 8'd5, 1'b0, 0, 32'h0, "R10");
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00cc; fill_asid = 8'd5;
    fill_pfn = 20'h00dd; fill_perm = 2'b11;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    look(32'h000c_c000, 8'd5, 1'b0, 0, 32'h0, "R10");
  endtask

  task automatic t_same_cycle();
    do_reset();
    // lookup and fill of the same tag in one cycle: old contents seen
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h00e0; fill_asid = 8'd6;
    fill_pfn = 20'h00f0; fill_perm = 2'b11;
    lk_valid = 1'b1; lk_vaddr = 32'h000e_0008; lk_asid = 8'd6; lk_store = 1'b0;
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    check(res_miss && res_valid, "R11", "lookup beside fill", 32'(res_miss), 1);
    look(32'h000e_0008, 8'd6, 1'b0, 2, 32'h000f_0008, "R11");
    // lookup beside flush still translates
    @(negedge clk);
    flush = 1'b1;
    lk_valid = 1'b1; lk_vaddr = 32'h000e_0010; lk_asid = 8'd6; lk_store = 1'b0;
    @(negedge clk);
    flush = 1'b0; lk_valid = 1'b0;
    check(res_pa_valid && res_paddr == 32'h000f_0010, "R11", "lookup beside flush",
          res_paddr, 32'h000f_0010);
  endtask

  initial begin
    t_reset();
    t_fill_hit();
    t_asid();
    t_perm();
    t_overwrite();
    t_replace();
    t_flush();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule